// File: doc/BRIEF.md
# Host Handshake Timeout Timer

This block is a watchdog for the peripheral side of a parallel port. The port controller pulses `wait_start` when it begins waiting for a handshake event from the host, and pulses `event_seen` when that event arrives. In between, a clock prescaler produces slow ticks and a 14-bit tick counter counts them. An 8-bit programmable limit sets the upper eight bits of the count at which the wait is declared dead. A timeout fires only on an exact match between the count and the limit. When it fires, the block loads a fixed negotiation status code, raises an interrupt and pulses `timeout_pulse`. It then stays in a locked state until the synchronized host pins show idle compatibility-mode levels.

Software reaches four byte registers through a simple write/read port: the limit, a control register with a two-bit debug field that stops the timer, the status register, and a read-only view of the live host handshake pins. Reading the status register acknowledges the interrupt. The negotiation machine and the data path are not part of this block.

Top module: `hs_timeout_top`

## Requirements
- R1: A `wait_start` sampled while not locked clears the tick counter to zero and restarts the prescaler. This applies during an active wait too, so the timeout is measured from the latest start.
- R2: The prescaler emits one tick every `PRESCALE_DIV` clock cycles (default 2048). The first tick after a start comes `PRESCALE_DIV` cycles after the start edge.
- R3: The limit register sits at address 0x28 and reads 0xFF after reset. With limit L, a timeout occurs when the counter equals L·64, which is `{L, 6'b0}`. `irq` and `timeout_pulse` go high after the clock edge L·64·`PRESCALE_DIV`+1 cycles after the edge that sampled `wait_start`.
- R4: A limit write during an active wait is used by the next compare, without a restart.
- R5: A timeout loads the status register (address 0x2A) with 0x22, in which bit 5 is the change flag and the low nibble 0010 means return to compatibility mode. In the same cycle it raises `irq` and gives a one-cycle `timeout_pulse`.
- R6: After a timeout, `locked` stays high and `wait_start` is ignored until the synchronized pins show A1284 low and nInit high. `locked` falls at the third clock edge after the pins reach that condition.
- R7: When the control register (address 0x29) holds a nonzero value in bits [3:2], no timeout fires and the wait may last forever. Control bits [3:2] read back, and the other control bits read 0.
- R8: A read of address 0x2E returns {4'b0, A1284, nInit, host busy, host clock} in bits 7..0. Each pin passes through a two-flop synchronizer, so a change shows at the second edge after it.
- R9: An `event_seen` in the same cycle as a compare match ends the wait with no timeout.
- R10: `irq` follows status bit 5 and stays high until a read of the status register, which clears bit 5 and leaves 0x02. A timeout in the same cycle as that read wins.
- R11: After reset, status reads 0x00, control reads 0x00, and `irq`, `locked` and `timeout_pulse` are low. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the same cycle as the address |
| wait_start | input | 1 | Port controller begins waiting for a host event |
| event_seen | input | 1 | Expected host event arrived |
| pin_a1284 | input | 1 | Host A1284 pin, asynchronous |
| pin_ninit | input | 1 | Host nInit pin, active low, asynchronous |
| pin_hbusy | input | 1 | Host busy pin, asynchronous |
| pin_hclk | input | 1 | Host clock pin, asynchronous |
| irq | output | 1 | Negotiation status change interrupt |
| timeout_pulse | output | 1 | One-cycle pulse when a timeout fires |
| locked | output | 1 | Locked return-to-compatibility state |

## Verification
The hardest case to reach is an event strobe that lands in exactly the same cycle as the compare match, one cycle too late for any earlier event and one cycle too early for a timeout. The bench uses a small prescaler divisor. It computes the match edge from the limit and places the event strobe on that edge, then on the edge after it, and also at random offsets spread on both sides. A restart part way through a wait and a limit rewrite during a wait move the match edge, and the bench checks that new edge to the exact cycle.

// File: rtl/hs_timeout_pkg.sv
package hs_timeout_pkg;

    typedef enum logic [1:0] {
        WT_IDLE = 2'd0,
        WT_WAIT = 2'd1,
        WT_LOCK = 2'd2
    } wt_state_e;

    localparam logic [7:0] ADDR_LIMIT  = 8'h28;
    localparam logic [7:0] ADDR_CTRL   = 8'h29;
    localparam logic [7:0] ADDR_STATUS = 8'h2A;
    localparam logic [7:0] ADDR_PINS   = 8'h2E;

    localparam logic [7:0] STATUS_TIMEOUT = 8'h22;
    localparam int         STATUS_FLAG    = 5;
    localparam int         DBG_LO         = 2;

endpackage

// File: rtl/hs_pin_sync.sv
module hs_pin_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_async,
    output logic [W-1:0] pins_sync
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = pins_async;
        r_d.s2 = r_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pins_sync = r_q.s2;

    AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(r_q.s1) |=> (r_q.s2 == $past(r_q.s1))); // R8
endmodule

// File: rtl/hs_tick_prescaler.sv
module hs_tick_prescaler #(
    parameter int DIV = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_t;

    pre_t r_q, r_d;

    always_comb begin
        r_d  = r_q;
        tick = (r_q.cnt == LAST);
        if (clr)       r_d.cnt = '0;
        else if (tick) r_d.cnt = '0;
        else           r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= LAST); // R2
    AST_PRESCALE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (r_q.cnt == '0)); // R1
endmodule

// File: rtl/hs_wait_timer.sv
module hs_wait_timer
    import hs_timeout_pkg::*;
#(
    parameter int CNT_W = 14,
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wait_start,
    input  logic             event_seen,
    input  logic             tick,
    input  logic             dbg_dis,
    input  logic             pins_idle,
    input  logic [LIM_W-1:0] limit,
    output logic             pre_clr,
    output logic             fire,
    output logic             timeout_pulse,
    output logic             locked
);
    localparam int SHIFT = CNT_W - LIM_W;

    typedef struct packed {
        wt_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } tmr_t;

    tmr_t r_q, r_d;
    logic [CNT_W-1:0] target;

    always_comb begin
        r_d       = r_q;
        r_d.pulse = 1'b0;
        fire      = 1'b0;
        pre_clr   = 1'b0;
        target    = {limit, {SHIFT{1'b0}}};
        unique case (r_q.state)
            WT_IDLE: begin
                if (wait_start) begin
                    r_d.state = WT_WAIT;
                    r_d.cnt   = '0;
                    pre_clr   = 1'b1;
                end
            end
            WT_WAIT: begin
                if (wait_start) begin
                    r_d.cnt = '0;
                    pre_clr = 1'b1;
                end else if (event_seen) begin
                    r_d.state = WT_IDLE;
                end else if (!dbg_dis) begin
                    if (r_q.cnt == target) begin
                        fire      = 1'b1;
                        r_d.pulse = 1'b1;
                        r_d.state = WT_LOCK;
                    end else if (tick) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            WT_LOCK: begin
                if (pins_idle) r_d.state = WT_IDLE;
            end
            default: r_d.state = WT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= WT_IDLE;
            r_q.cnt   <= '0;
            r_q.pulse <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign timeout_pulse = r_q.pulse;
    assign locked        = (r_q.state == WT_LOCK);

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_start && r_q.state != WT_LOCK) |=> (r_q.cnt == '0 && r_q.state == WT_WAIT)); // R1
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == WT_WAIT && event_seen && !wait_start) |=> (!r_q.pulse && r_q.state == WT_IDLE)); // R9
    AST_DEBUG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == WT_WAIT && dbg_dis) |=> !r_q.pulse); // R7
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == WT_LOCK && !pins_idle) |=> (r_q.state == WT_LOCK)); // R6
    AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == WT_LOCK && pins_idle) |=> (r_q.state == WT_IDLE)); // R6
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pulse |=> !r_q.pulse); // R5
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == WT_WAIT && r_d.state == WT_WAIT && !wait_start) |=>
            (r_q.cnt == $past(r_q.cnt) || r_q.cnt == $past(r_q.cnt) + 1'b1)); // R2
endmodule

// File: rtl/hs_host_regs.sv
module hs_host_regs
    import hs_timeout_pkg::*;
#(
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [7:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    input  logic             fire,
    input  logic [3:0]       pins_sync,
    output logic [7:0]       reg_rdata,
    output logic [LIM_W-1:0] limit,
    output logic             dbg_dis,
    output logic             irq
);
    typedef struct packed {
        logic [LIM_W-1:0] limit;
        logic [1:0]       dbg;
        logic [7:0]       status;
    } regs_t;

    regs_t r_q, r_d;
    logic  status_rd;

    always_comb begin
        r_d       = r_q;
        status_rd = reg_rd && (reg_addr == ADDR_STATUS);
        if (reg_wr && reg_addr == ADDR_LIMIT) r_d.limit = reg_wdata[LIM_W-1:0];
        if (reg_wr && reg_addr == ADDR_CTRL)  r_d.dbg   = reg_wdata[DBG_LO+1:DBG_LO];
        if (fire)           r_d.status = STATUS_TIMEOUT;
        else if (status_rd) r_d.status[STATUS_FLAG] = 1'b0;
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_LIMIT:  reg_rdata = 8'(r_q.limit);
            ADDR_CTRL:   reg_rdata = {4'b0, r_q.dbg, 2'b0};
            ADDR_STATUS: reg_rdata = r_q.status;
            ADDR_PINS:   reg_rdata = {4'b0, pins_sync};
            default:     reg_rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.limit  <= '1;
            r_q.dbg    <= '0;
            r_q.status <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign limit   = r_q.limit;
    assign dbg_dis = |r_q.dbg;
    assign irq     = r_q.status[STATUS_FLAG];

    AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (r_q.status == STATUS_TIMEOUT)); // R5
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !status_rd) |=> irq); // R10
    AST_READ_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !fire) |=> !irq); // R10
    AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADDR_LIMIT) |=> $stable(r_q.limit)); // R3
endmodule

// File: rtl/hs_timeout_top.sv
module hs_timeout_top
    import hs_timeout_pkg::*;
#(
    parameter int CNT_W        = 14,
    parameter int LIM_W        = 8,
    parameter int PRESCALE_DIV = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       wait_start,
    input  logic       event_seen,
    input  logic       pin_a1284,
    input  logic       pin_ninit,
    input  logic       pin_hbusy,
    input  logic       pin_hclk,
    output logic       irq,
    output logic       timeout_pulse,
    output logic       locked
);
    logic [3:0]       pins_sync;
    logic             pins_idle;
    logic             tick;
    logic             pre_clr;
    logic             fire;
    logic             dbg_dis;
    logic [LIM_W-1:0] limit;

    hs_pin_sync #(.W(4)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_async ({pin_a1284, pin_ninit, pin_hbusy, pin_hclk}),
        .pins_sync  (pins_sync)
    );

    assign pins_idle = !pins_sync[3] && pins_sync[2];

    hs_tick_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pre_clr),
        .tick  (tick)
    );

    hs_wait_timer #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_tmr (
        .clk           (clk),
        .rst_n         (rst_n),
        .wait_start    (wait_start),
        .event_seen    (event_seen),
        .tick          (tick),
        .dbg_dis       (dbg_dis),
        .pins_idle     (pins_idle),
        .limit         (limit),
        .pre_clr       (pre_clr),
        .fire          (fire),
        .timeout_pulse (timeout_pulse),
        .locked        (locked)
    );

    hs_host_regs #(.LIM_W(LIM_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .fire      (fire),
        .pins_sync (pins_sync),
        .reg_rdata (reg_rdata),
        .limit     (limit),
        .dbg_dis   (dbg_dis),
        .irq       (irq)
    );

    AST_IRQ_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> (irq && locked)); // R5
endmodule

// File: tb/test_hs_timeout_top.sv
module test_hs_timeout_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       wait_start = 1'b0, event_seen = 1'b0;
    logic       pin_a1284 = 1'b0, pin_ninit = 1'b1, pin_hbusy = 1'b0, pin_hclk = 1'b0;
    logic       irq, timeout_pulse, locked;

    int total = 0;
    int fails = 0;
    logic [7:0] exp_status = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    hs_timeout_top #(.PRESCALE_DIV(DIV)) i_hs_timeout_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wait_start(wait_start), .event_seen(event_seen),
        .pin_a1284(pin_a1284), .pin_ninit(pin_ninit), .pin_hbusy(pin_hbusy),
        .pin_hclk(pin_hclk), .irq(irq), .timeout_pulse(timeout_pulse), .locked(locked)
    );

    function automatic int match_edge(input int lim);
        return lim * 64 * DIV + 1;
    endfunction

    function automatic bit expect_timeout(input int lim, input int ev_edge);
        return (ev_edge == 0) || (ev_edge > match_edge(lim));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic check_status(input string req);
        logic [7:0] v;
        rd_reg(8'h2A, v);
        chk(v == exp_status, req, v, exp_status);
        exp_status[5] = 1'b0;
    endtask

    // Pulse wait_start; returns at negedge N1 (start edge E0 has passed).
    task automatic start_wait();
        wait_start = 1'b1;
        @(negedge clk);
        wait_start = 1'b0;
    endtask

    // Run one wait with an event at edge ev (0 = never); ends idle or locked.
    task automatic run_wait(input int lim, input int ev);
        bit to;
        start_wait();
        for (int k = 1; k <= match_edge(lim) + 8; k++) begin
            event_seen = (k == ev);
            @(negedge clk);
        end
        event_seen = 1'b0;
        to = expect_timeout(lim, ev);
        chk(irq == to, "R9 timeout vs event", irq, to);
        if (to) exp_status = 8'h22;
        check_status("R10 status after wait");
        chk(irq == 1'b0, "R10 irq cleared by read", irq, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int seed;
        seed = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk(irq == 0 && locked == 0 && timeout_pulse == 0, "R11 outputs after reset",
            {irq, locked, timeout_pulse}, 0);
        rd_reg(8'h2A, v); chk(v == 8'h00, "R11 status reset", v, 8'h00);
        rd_reg(8'h29, v); chk(v == 8'h00, "R11 ctrl reset", v, 8'h00);
        rd_reg(8'h13, v); chk(v == 8'h00, "R11 unmapped reads zero", v, 8'h00);
        rd_reg(8'h28, v); chk(v == 8'hFF, "R3 limit reset value", v, 8'hFF);

        // R3/R2 default limit, exact match edge
        start_wait();
        repeat (match_edge(255) - 1) @(negedge clk);
        chk(irq == 0, "R3 no irq one edge before match", irq, 0);
        @(negedge clk);
        chk(irq == 1 && timeout_pulse == 1, "R3 timeout at limit 0xFF", {irq, timeout_pulse}, 3);
        @(negedge clk);
        chk(timeout_pulse == 0, "R5 pulse one cycle", timeout_pulse, 0);
        exp_status = 8'h22;
        check_status("R5 status code 0x22");
        repeat (4) @(negedge clk);

        // R2 exact timing with limit 1
        wr_reg(8'h28, 8'h01);
        rd_reg(8'h28, v); chk(v == 8'h01, "R3 limit readback", v, 8'h01);
        start_wait();
        repeat (match_edge(1) - 1) @(negedge clk);
        chk(irq == 0, "R2 no irq before 64 ticks", irq, 0);
        @(negedge clk);
        chk(irq == 1, "R2 irq after 64 ticks", irq, 1);
        exp_status = 8'h22;
        check_status("R5 status");
        repeat (4) @(negedge clk);

        // R1 restart in the middle of a wait
        start_wait();
        repeat (99) @(negedge clk);
        start_wait();
        repeat (match_edge(1) - 1) @(negedge clk);
        chk(irq == 0, "R1 restart moves match", irq, 0);
        @(negedge clk);
        chk(irq == 1, "R1 timeout after restart", irq, 1);
        exp_status = 8'h22;
        check_status("R10 ack");
        repeat (4) @(negedge clk);

        // R4 limit rewrite during wait
        wr_reg(8'h28, 8'h03);
        start_wait();
        repeat (20) @(negedge clk);
        wr_reg(8'h28, 8'h01);
        repeat (match_edge(1) - 22) @(negedge clk);
        chk(irq == 0, "R4 new limit not yet matched", irq, 0);
        @(negedge clk);
        chk(irq == 1, "R4 new limit used", irq, 1);
        exp_status = 8'h22;
        check_status("R4 status");
        repeat (4) @(negedge clk);

        // R9 directed edges
        run_wait(1, match_edge(1));
        run_wait(1, match_edge(1) + 1);
        run_wait(1, match_edge(1) - 1);

        // R6 lock holds while pins are not idle
        pin_a1284 = 1'b1;
        start_wait();
        repeat (match_edge(1)) @(negedge clk);
        chk(locked == 1, "R6 locked after timeout", locked, 1);
        start_wait();
        repeat (10) @(negedge clk);
        chk(locked == 1 && timeout_pulse == 0, "R6 wait_start ignored when locked",
            {locked, timeout_pulse}, 2);
        exp_status = 8'h22;
        check_status("R10 read while locked");
        chk(irq == 0, "R10 irq cleared", irq, 0);
        pin_a1284 = 1'b0;
        repeat (2) @(negedge clk);
        chk(locked == 1, "R6 lock held during sync delay", locked, 1);
        @(negedge clk);
        chk(locked == 0, "R6 lock released on idle pins", locked, 0);

        // R7 debug disable
        wr_reg(8'h29, 8'h08);
        rd_reg(8'h29, v); chk(v == 8'h08, "R7 ctrl readback", v, 8'h08);
        start_wait();
        repeat (match_edge(1) * 2) @(negedge clk);
        chk(irq == 0 && locked == 0, "R7 no timeout when disabled", {irq, locked}, 0);
        event_seen = 1'b1; @(negedge clk); event_seen = 1'b0;
        wr_reg(8'h29, 8'h00);

        // R8 pin view
        for (int i = 0; i < 6; i++) begin
            logic [3:0] p;
            p = 4'($urandom());
            {pin_a1284, pin_ninit, pin_hbusy, pin_hclk} = p;
            repeat (2) @(negedge clk);
            rd_reg(8'h2E, v);
            chk(v == {4'b0, p}, "R8 pin register", v, {4'b0, p});
        end
        pin_a1284 = 1'b0; pin_ninit = 1'b1;
        repeat (4) @(negedge clk);

        // Random event placement around the match edge
        for (int i = 0; i < 10; i++) begin
            int lim;
            int ev;
            lim = 1 + int'($urandom_range(2));
            wr_reg(8'h28, 8'(lim));
            ev = (i == 0) ? 0 : 1 + int'($urandom_range(match_edge(lim) + 6));
            run_wait(lim, ev);
            repeat (4) @(negedge clk);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule